// File: doc/BRIEF.md
# Per-Core Tick Timer Array

This block holds a row of independent tick timers, one for each processor core, behind a single 32-bit register bus. Each timer runs a two-stage count. A prescaler divides the block clock into ticks, and a countdown counter consumes those ticks and raises an expiry flag when it reaches zero. In periodic operation the countdown refills itself from its buffer. In one-shot operation it stops at zero. Each timer drives its own interrupt line.

Software sees one 256-byte register window per timer. Writes to the reload, countdown and control registers do not take effect at once. Each is applied a fixed number of cycles after the bus write, and at that same moment a per-window write-status bit is set. Software can poll that bit to learn when the value has landed. The register bus is a plain strobe interface and has no back-pressure. A write completes on the cycle it is presented. A read is answered exactly one cycle later.

Top module: `core_tick_timers`

## Requirements
- R1: Timer n decodes the window that starts at byte address 0x300 + 0x100*n. Inside a window the offsets are: 0x00 tick reload, 0x08 countdown buffer, 0x20 control, 0x30 expiry status, 0x34 interrupt enable, 0x40 write status. Any other address, including windows past the last timer, reads as zero, and writes to it change nothing.
- R2: A write to offset 0x00, 0x08 or 0x20 changes that register's readback, and the timer behaviour it controls, exactly APPLY_DLY (default 4) clock edges after the edge that sampled the write.
- R3: Write status bit 0, bit 1 and bit 3 are set when a tick reload write, a countdown buffer write and a control write are applied, in that order of bits. Writing 1 to a bit clears it. A set in the same cycle as a clear wins.
- R4: While control bit 0 is 1, the prescaler issues one tick every (tick reload + 1) clock cycles. When control bit 0 is 0, no ticks are issued and the prescale phase restarts from zero.
- R5: While control bit 1 is 1, each tick decrements a nonzero countdown by one. The tick that takes it from 1 to 0 sets status bit 0.
- R6: On expiry with control bit 2 set, the countdown reloads from the countdown buffer, which gives periodic interrupts. With bit 2 clear it stays at zero and does not expire again.
- R7: A countdown buffer write applies bits 30:0 to the buffer. If bit 31 of that write is 1, the same value is also loaded into the countdown and no tick is counted in that cycle. If bit 31 is 0, the running countdown is left alone.
- R8: Writing 1 to status bit 0 clears it. An expiry in the same cycle keeps it set.
- R9: tick_irq[n] is high exactly when timer n's status bit 0 and enable bit 0 are both 1. Writes to the enable register take effect on the next edge.
- R10: A read strobe yields bus_rvalid high on the next cycle, with bus_rdata holding the register value as it stood before that edge. bus_rvalid is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe |
| bus_rd_en | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read answer strobe |
| tick_irq | output | N_TIMERS | Per-timer interrupt lines |

## Verification
The bench builds the block with three timers and leaves the other parameters at their defaults. With three timers, the fourth window at 0x600 is unmapped space just past the last real window, so decode at the upper edge can be tested next to the lower edge below 0x300. The reference model tracks every timer on every clock. This lets the bench compare the four-cycle apply window, a status clear that lands on the cycle a write is applied, and buffer-only updates to a running periodic countdown, all on every cycle.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int WIN_BASE = 'h300;
  localparam int WIN_SPAN = 256;

  localparam logic [7:0] OFF_TICK  = 8'h00;
  localparam logic [7:0] OFF_ICNT  = 8'h08;
  localparam logic [7:0] OFF_CTRL  = 8'h20;
  localparam logic [7:0] OFF_STAT  = 8'h30;
  localparam logic [7:0] OFF_IEN   = 8'h34;
  localparam logic [7:0] OFF_WSTAT = 8'h40;

  localparam int WS_TICK = 0;
  localparam int WS_ICNT = 1;
  localparam int WS_CTRL = 3;

  localparam int CTL_RUN  = 0;
  localparam int CTL_INT  = 1;
  localparam int CTL_IVAL = 2;

  localparam int LOAD_BIT = 31;

  typedef enum logic [1:0] {
    OPK_TICK = 2'd0,
    OPK_ICNT = 2'd1,
    OPK_CTRL = 2'd2
  } opk_e;

  typedef struct packed {
    logic        vld;
    opk_e        kind;
    logic [31:0] data;
  } wr_op_t;
endpackage

// File: rtl/tt_apply_pipe.sv
module tt_apply_pipe
  import tt_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  wr_op_t op_in,
  output wr_op_t op_out
);
  wr_op_t stage [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
    end else begin
      stage[0] <= op_in;
      for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
    end
  end

  assign op_out = stage[DEPTH-1];
endmodule

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] reload,
  output logic         tick
);
  logic [W-1:0] phase;

  assign tick = run && (phase >= reload);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            phase <= '0;
    else if (!run || tick) phase <= '0;
    else                   phase <= phase + 1'b1;
  end

  // R4: a stopped prescaler restarts its phase from zero
  a_r4_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (phase == '0));
endmodule

// File: rtl/tt_countdown.sv
module tt_countdown #(
  parameter int W = 31
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         int_on,
  input  logic         interval,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] reload_val,
  output logic         expire
);
  logic [W-1:0] cnt;
  logic         step;

  assign step   = int_on && tick && !load && (cnt != '0);
  assign expire = step && (cnt == W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (load)   cnt <= load_val;
    else if (expire) cnt <= interval ? reload_val : '0;
    else if (step)   cnt <= cnt - 1'b1;
  end

  a_r5_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (int_on && tick && !load && cnt > W'(1)) |=> (cnt == $past(cnt) - W'(1)));

  a_r6_oneshot_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !interval) |=> (cnt == '0));

  a_r6_periodic_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && interval) |=> (cnt == $past(reload_val)));

  a_r7_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(load_val)));
endmodule

// File: rtl/tt_core.sv
module tt_core
  import tt_pkg::*;
#(
  parameter int TICK_W    = 32,
  parameter int CNT_W     = 31,
  parameter int APPLY_DLY = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  wr_off,
  input  logic [31:0] wr_data,
  input  logic [7:0]  rd_off,
  output logic [31:0] rd_word,
  output logic        irq
);
  logic [TICK_W-1:0] tick_buf;
  logic [CNT_W-1:0]  icnt_buf;
  logic [2:0]        ctrl;
  logic              stat, ien;
  logic [3:0]        wstat;

  wr_op_t op_in, op_ap;
  logic   ap_tick, ap_icnt, ap_ctrl, icnt_load;
  logic   tick, expire;
  logic   stat_clr;
  logic [3:0] ws_clr, ws_set;

  always_comb begin
    op_in      = '0;
    op_in.data = wr_data;
    if (wr_en) begin
      case (wr_off)
        OFF_TICK: begin op_in.vld = 1'b1; op_in.kind = OPK_TICK; end
        OFF_ICNT: begin op_in.vld = 1'b1; op_in.kind = OPK_ICNT; end
        OFF_CTRL: begin op_in.vld = 1'b1; op_in.kind = OPK_CTRL; end
        default:  op_in.vld = 1'b0;
      endcase
    end
  end

  tt_apply_pipe #(.DEPTH(APPLY_DLY)) u_pipe (
    .clk(clk), .rst_n(rst_n), .op_in(op_in), .op_out(op_ap)
  );

  assign ap_tick   = op_ap.vld && (op_ap.kind == OPK_TICK);
  assign ap_icnt   = op_ap.vld && (op_ap.kind == OPK_ICNT);
  assign ap_ctrl   = op_ap.vld && (op_ap.kind == OPK_CTRL);
  assign icnt_load = ap_icnt && op_ap.data[LOAD_BIT];

  tt_prescaler #(.W(TICK_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(ctrl[CTL_RUN]), .reload(tick_buf), .tick(tick)
  );

  tt_countdown #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .int_on(ctrl[CTL_INT]), .interval(ctrl[CTL_IVAL]),
    .tick(tick), .load(icnt_load), .load_val(op_ap.data[CNT_W-1:0]),
    .reload_val(icnt_buf), .expire(expire)
  );

  assign stat_clr = wr_en && (wr_off == OFF_STAT) && wr_data[0];
  assign ws_clr   = (wr_en && (wr_off == OFF_WSTAT)) ? wr_data[3:0] : 4'b0;

  always_comb begin
    ws_set          = 4'b0;
    ws_set[WS_TICK] = ap_tick;
    ws_set[WS_ICNT] = ap_icnt;
    ws_set[WS_CTRL] = ap_ctrl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_buf <= '0;
      icnt_buf <= '0;
      ctrl     <= '0;
      stat     <= 1'b0;
      ien      <= 1'b0;
      wstat    <= '0;
    end else begin
      if (ap_tick) tick_buf <= op_ap.data[TICK_W-1:0];
      if (ap_icnt) icnt_buf <= op_ap.data[CNT_W-1:0];
      if (ap_ctrl) ctrl     <= op_ap.data[2:0];
      stat  <= (stat && !stat_clr) || expire;
      if (wr_en && (wr_off == OFF_IEN)) ien <= wr_data[0];
      wstat <= (wstat & ~ws_clr) | ws_set;
    end
  end

  assign irq = stat && ien;

  always_comb begin
    case (rd_off)
      OFF_TICK:  rd_word = 32'(tick_buf);
      OFF_ICNT:  rd_word = 32'(icnt_buf);
      OFF_CTRL:  rd_word = 32'(ctrl);
      OFF_STAT:  rd_word = 32'(stat);
      OFF_IEN:   rd_word = 32'(ien);
      OFF_WSTAT: rd_word = 32'(wstat);
      default:   rd_word = '0;
    endcase
  end

  a_r5_expiry_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> stat);

  a_r8_clear_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !expire) |=> !stat);

  a_r3_ctrl_apply_status: assert property (@(posedge clk) disable iff (!rst_n)
    ap_ctrl |=> wstat[WS_CTRL]);

  a_r3_bit2_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !wstat[2]);
endmodule

// File: rtl/core_tick_timers.sv
module core_tick_timers
  import tt_pkg::*;
#(
  parameter int N_TIMERS  = 4,
  parameter int ADDR_W    = 12,
  parameter int TICK_W    = 32,
  parameter int CNT_W     = 31,
  parameter int APPLY_DLY = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr_en,
  input  logic                bus_rd_en,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic                bus_rvalid,
  output logic [N_TIMERS-1:0] tick_irq
);
  localparam int WIN_END = WIN_BASE + N_TIMERS * WIN_SPAN;

  logic [31:0] addr32, win_idx, rd_mux;
  logic        in_range;
  logic [31:0] words [N_TIMERS];

  assign addr32   = 32'(bus_addr);
  assign in_range = (addr32 >= 32'(WIN_BASE)) && (addr32 < 32'(WIN_END));
  assign win_idx  = (addr32 - 32'(WIN_BASE)) >> 8;

  for (genvar n = 0; n < N_TIMERS; n++) begin : g_tmr
    logic hit;
    assign hit = in_range && (win_idx == 32'(n));

    tt_core #(.TICK_W(TICK_W), .CNT_W(CNT_W), .APPLY_DLY(APPLY_DLY)) u_core (
      .clk(clk), .rst_n(rst_n),
      .wr_en(bus_wr_en && hit), .wr_off(bus_addr[7:0]), .wr_data(bus_wdata),
      .rd_off(bus_addr[7:0]), .rd_word(words[n]), .irq(tick_irq[n])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int n = 0; n < N_TIMERS; n++)
      if (in_range && (win_idx == 32'(n))) rd_mux = words[n];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd_en;
      if (bus_rd_en) bus_rdata <= rd_mux;
    end
  end

  a_r10_answer_next: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_en |=> bus_rvalid);

  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_en |=> !bus_rvalid);

  a_r1_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_en && !in_range) |=> (bus_rdata == '0));
endmodule

// File: tb/core_tick_timers_tb.sv
`timescale 1ns/1ps
module core_tick_timers_tb;
  localparam int NT = 3, AW = 12, DLY = 4;

  logic          clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  wire  [31:0]   rdata;
  wire           rvalid;
  wire  [NT-1:0] irq;

  always #2 clk = ~clk;

  core_tick_timers #(.N_TIMERS(NT), .ADDR_W(AW), .APPLY_DLY(DLY)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(wr_en), .bus_rd_en(rd_en),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .bus_rvalid(rvalid), .tick_irq(irq)
  );

  int    checks = 0, errors = 0;
  string tag = "R10";
  bit    done = 1'b0;

  logic [31:0] m_tick[NT], m_icb[NT], m_ctrl[NT], m_stat[NT];
  logic [31:0] m_ien[NT], m_ws[NT], m_pre[NT], m_cnt[NT];
  typedef struct { int due; int tmr; int kind; logic [31:0] d; } pend_t;
  pend_t       pq[$];
  int          cyc = 0;
  bit          e_rv = 1'b0;
  logic [31:0] e_rd = '0;

  function automatic bit mapped(logic [31:0] a);
    return (a >= 32'h300) && (a < 32'h300 + NT * 256);
  endfunction

  function automatic logic [31:0] mread(logic [31:0] a);
    int n;
    if (!mapped(a)) return 32'h0;
    n = int'((a - 32'h300) >> 8);
    case (a[7:0])
      8'h00: return m_tick[n];
      8'h08: return m_icb[n];
      8'h20: return m_ctrl[n];
      8'h30: return m_stat[n];
      8'h34: return m_ien[n];
      8'h40: return m_ws[n];
      default: return 32'h0;
    endcase
  endfunction

  // behavioural reference, advanced on every edge
  always @(posedge clk or negedge rst_n) begin : model
    logic [31:0] a, o_icb, o_ctrl, o_cnt, ldv;
    bit tk, ld, ex, hit;
    if (!rst_n) begin
      for (int n = 0; n < NT; n++) begin
        m_tick[n] = 0; m_icb[n] = 0; m_ctrl[n] = 0; m_stat[n] = 0;
        m_ien[n] = 0; m_ws[n] = 0; m_pre[n] = 0; m_cnt[n] = 0;
      end
      pq.delete(); cyc = 0; e_rv = 0;
    end else begin
      a = 32'(addr);
      e_rv = rd_en;
      if (rd_en) e_rd = mread(a);
      for (int n = 0; n < NT; n++) begin
        hit = wr_en && mapped(a) && (int'((a - 32'h300) >> 8) == n);
        o_icb = m_icb[n]; o_ctrl = m_ctrl[n]; o_cnt = m_cnt[n];
        tk = 0;
        if (o_ctrl[0]) begin
          tk = (m_pre[n] >= m_tick[n]);
          m_pre[n] = tk ? 32'h0 : m_pre[n] + 1;
        end else m_pre[n] = 0;
        if (hit && a[7:0] == 8'h40) m_ws[n] = m_ws[n] & ~(wdata & 32'hf);
        ld = 0; ldv = 0;
        foreach (pq[i]) if (pq[i].due == cyc && pq[i].tmr == n) begin
          case (pq[i].kind)
            0: begin m_tick[n] = pq[i].d; m_ws[n] |= 32'h1; end
            1: begin
                 m_icb[n] = pq[i].d & 32'h7fff_ffff; m_ws[n] |= 32'h2;
                 if (pq[i].d[31]) begin ld = 1; ldv = pq[i].d & 32'h7fff_ffff; end
               end
            default: begin m_ctrl[n] = pq[i].d & 32'h7; m_ws[n] |= 32'h8; end
          endcase
        end
        ex = 0;
        if (ld) m_cnt[n] = ldv;
        else if (o_ctrl[1] && tk && o_cnt != 0) begin
          if (o_cnt == 1) begin ex = 1; m_cnt[n] = o_ctrl[2] ? o_icb : 32'h0; end
          else m_cnt[n] = o_cnt - 1;
        end
        if (hit && a[7:0] == 8'h30 && wdata[0]) m_stat[n] = 0;
        if (ex) m_stat[n] = 1;
        if (hit && a[7:0] == 8'h34) m_ien[n] = 32'(wdata[0]);
      end
      for (int i = pq.size() - 1; i >= 0; i--) if (pq[i].due == cyc) pq.delete(i);
      if (wr_en && mapped(a)) begin
        int n, k;
        n = int'((a - 32'h300) >> 8);
        k = (a[7:0] == 8'h00) ? 0 : (a[7:0] == 8'h08) ? 1 : (a[7:0] == 8'h20) ? 2 : -1;
        if (k >= 0) pq.push_back('{cyc + DLY, n, k, wdata});
      end
      cyc++;
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int n = 0; n < NT; n++) begin
        checks++;
        if (irq[n] !== (m_stat[n][0] & m_ien[n][0])) begin
          errors++;
          $display("FAIL %s tick_irq[%0d] actual=%b expected=%b", tag, n, irq[n],
                   m_stat[n][0] & m_ien[n][0]);
        end
      end
      checks++;
      if (rvalid !== e_rv) begin
        errors++;
        $display("FAIL %s bus_rvalid actual=%b expected=%b", tag, rvalid, e_rv);
      end else if (e_rv) begin
        checks++;
        if (rdata !== e_rd) begin
          errors++;
          $display("FAIL %s bus_rdata actual=%h expected=%h", tag, rdata, e_rd);
        end
      end
    end
  end

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    addr = a[AW-1:0]; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a);
    addr = a[AW-1:0]; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic rd_all(input logic [31:0] base);
    rd(base + 'h00); rd(base + 'h08); rd(base + 'h20);
    rd(base + 'h30); rd(base + 'h34); rd(base + 'h40);
  endtask

  localparam logic [31:0] T0 = 32'h300, T1 = 32'h400, T2 = 32'h500;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    tag = "R10";                       // reset values and read timing
    rd_all(T0); rd_all(T2);

    tag = "R2";                        // apply delay, read every cycle
    wr(T0 + 'h00, 32'd7);
    for (int i = 0; i < 6; i++) rd(T0 + 'h00);
    rd(T0 + 'h40);

    tag = "R3";                        // write status clear and set-wins
    wr(T0 + 'h40, 32'h1); rd(T0 + 'h40);
    wr(T0 + 'h08, 32'h5); idle(3);
    wr(T0 + 'h40, 32'h2); rd(T0 + 'h40);
    wr(T0 + 'h20, 32'h0); idle(5); rd(T0 + 'h40);
    wr(T0 + 'h40, 32'hb); rd(T0 + 'h40);

    tag = "R4";                        // prescaler alone
    wr(T1 + 'h00, 32'd2); wr(T1 + 'h34, 32'h1);
    wr(T1 + 'h20, 32'h1); idle(12);

    tag = "R5";                        // one-shot countdown
    wr(T1 + 'h08, 32'h8000_0005); wr(T1 + 'h20, 32'h3);
    idle(30); rd(T1 + 'h30);

    tag = "R8";
    wr(T1 + 'h30, 32'h1); rd(T1 + 'h30);

    tag = "R6";                        // one-shot stays quiet, then periodic
    idle(40);
    wr(T2 + 'h00, 32'd1); wr(T2 + 'h34, 32'h1);
    wr(T2 + 'h08, 32'h8000_0003); wr(T2 + 'h20, 32'h7);
    for (int i = 0; i < 5; i++) begin idle(7); wr(T2 + 'h30, 32'h1); end

    tag = "R7";                        // buffer-only update while running
    wr(T2 + 'h08, 32'd10);
    for (int i = 0; i < 6; i++) begin idle(9); wr(T2 + 'h30, 32'h1); end
    wr(T2 + 'h08, 32'h8000_0002);
    for (int i = 0; i < 3; i++) begin idle(6); wr(T2 + 'h30, 32'h1); end

    tag = "R9";                        // enable gating
    wr(T2 + 'h34, 32'h0); idle(25); rd(T2 + 'h30);
    wr(T2 + 'h34, 32'h1); idle(3);

    tag = "R1";                        // decode and unmapped space
    wr(32'h620, 32'h7); wr(32'h010, 32'h5); wr(T0 + 'h10, 32'h9);
    wr(32'h6fc, 32'h1); idle(6);
    rd(32'h620); rd(32'h010); rd(T0 + 'h10); rd(32'h2fc); rd(32'h600);
    rd_all(T0); rd_all(T1); rd_all(T2);

    tag = "R4";                        // stopping the prescaler
    wr(T2 + 'h20, 32'h0); idle(12); rd(T2 + 'h30);
    wr(T2 + 'h30, 32'h1); idle(20);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule